// File: doc/BRIEF.md
# Root Hub Port Status and Control Register

This block holds the status and control register of one downstream port of a USB host root hub. Reads return a snapshot of the port: whether a device is attached, whether the port is enabled, suspended, over-current, in reset or powered, and whether the attached device is low speed. Five change flags in the upper half-word record events that software has not yet acknowledged. Software acknowledges an event by writing 1 to its flag.

Writes do not store data. Each of the low command bits acts as a one-shot set or clear request, and that request usually differs from what the same bit reports on a read. Writing 0 to a bit never changes anything. The port logic supplies the connect, over-current and low-speed levels and a strobe that marks the end of a reset pulse. The block drives the reset request to that logic and raises a summary change output for the interrupt tree.

Top module: `rh_port_reg`

## Requirements
- R1: After reset the read value is 0, and `change_o` and `port_reset_o` are low.
- R2: The read word carries connect at bit 0, enable at bit 1, suspend at bit 2, over-current at bit 3, reset at bit 4, power at bit 8 and low-speed at bit 9. Connect, over-current and low-speed follow their inputs one cycle later. Low-speed reads 0 while nothing is connected.
- R3: Writing 1 to bit 1 enables the port only if a device is connected. Otherwise the write is ignored and the connect-change flag is set. Writing 1 to bit 0 disables the port and also clears suspend. If both bits are written together, the clear takes effect.
- R4: Writing 1 to bit 2 suspends the port, but only while it is enabled. Writing 1 to bit 3 ends the suspend, and if the port was suspended it also sets the suspend-change flag.
- R5: Writing 1 to bit 4 starts a reset and raises `port_reset_o`, but only while a device is connected. Otherwise the connect-change flag is set. A `reset_done_i` pulse during a reset clears the reset, enables the port, clears suspend and sets the reset-change flag. The pulse is ignored when no reset is in progress.
- R6: Writing 1 to bit 8 powers the port. Writing 1 to bit 9 removes power. If both bits are written together, power is removed.
- R7: The change flags are connect (bit 16), enable (17), suspend (18), over-current (19) and reset-complete (20). Writing 1 to a flag clears it. A hardware event that sets the same flag in the same cycle wins over the clear.
- R8: A change on the connect input sets connect-change, and a change on the over-current input sets over-current-change. A disconnect also clears enable, suspend and reset, and sets enable-change if the port was enabled.
- R9: A write with value 0 changes no state.
- R10: `change_o` is high exactly when at least one change flag is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Register write strobe |
| wr_data_i | input | 32 | Write data (commands and flag clears) |
| rd_data_o | output | 32 | Register read value |
| connect_i | input | 1 | Device-present level from port logic |
| overcurrent_i | input | 1 | Over-current level from port logic |
| low_speed_i | input | 1 | Low-speed device level from port logic |
| reset_done_i | input | 1 | End-of-reset-pulse strobe |
| port_reset_o | output | 1 | Reset request to port logic |
| change_o | output | 1 | OR of all change flags |

## Verification
All port state is visible in the read word, so a wrong internal bit appears at `rd_data_o` on the first cycle after the write or input edge that caused it. A refused command, or an acknowledge that loses to a hardware event, shows up in the flag half of the word in that same cycle. A stuck flag shows up on `change_o`, and a reset that never ends shows up on `port_reset_o`. The bench checks the full word, the change output and the reset request after every cycle of stimulus, so any divergence is caught within one cycle of its cause.

// File: rtl/rh_port_pkg.sv
`timescale 1ns/1ps
package rh_port_pkg;
  localparam int REG_W   = 32;
  localparam int CHG_N   = 5;
  localparam int CHG_LSB = 16;

  // bit positions shared by read layout and command decode
  localparam int B_CONN  = 0;
  localparam int B_EN    = 1;
  localparam int B_SUSP  = 2;
  localparam int B_OC    = 3;
  localparam int B_RST   = 4;
  localparam int B_PWR   = 8;
  localparam int B_LS    = 9;

  // change flag indices, offset by CHG_LSB in the word
  localparam int F_CONN  = 0;
  localparam int F_EN    = 1;
  localparam int F_SUSP  = 2;
  localparam int F_OC    = 3;
  localparam int F_RST   = 4;

  typedef struct packed {
    logic clr_en;
    logic set_en;
    logic set_susp;
    logic clr_susp;
    logic set_rst;
    logic set_pwr;
    logic clr_pwr;
  } port_cmd_t;
endpackage

// File: rtl/rh_port_cmd.sv
`timescale 1ns/1ps
module rh_port_cmd
  import rh_port_pkg::*;
(
  input  logic             wr_en_i,
  input  logic [REG_W-1:0] wr_data_i,
  output port_cmd_t        cmd_o,
  output logic [CHG_N-1:0] chg_clr_o
);
  always_comb begin
    cmd_o.clr_en   = wr_en_i & wr_data_i[B_CONN];
    cmd_o.set_en   = wr_en_i & wr_data_i[B_EN];
    cmd_o.set_susp = wr_en_i & wr_data_i[B_SUSP];
    cmd_o.clr_susp = wr_en_i & wr_data_i[B_OC];
    cmd_o.set_rst  = wr_en_i & wr_data_i[B_RST];
    cmd_o.set_pwr  = wr_en_i & wr_data_i[B_PWR];
    cmd_o.clr_pwr  = wr_en_i & wr_data_i[B_LS];
  end

  for (genvar i = 0; i < CHG_N; i++) begin : g_clr
    assign chg_clr_o[i] = wr_en_i & wr_data_i[CHG_LSB+i];
  end
endmodule

// File: rtl/rh_port_state.sv
`timescale 1ns/1ps
module rh_port_state
  import rh_port_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  port_cmd_t        cmd_i,
  input  logic             connect_i,
  input  logic             overcurrent_i,
  input  logic             low_speed_i,
  input  logic             reset_done_i,
  output logic             ccs_o,
  output logic             pes_o,
  output logic             pss_o,
  output logic             poci_o,
  output logic             prs_o,
  output logic             pps_o,
  output logic             lsda_o,
  output logic [CHG_N-1:0] chg_set_o
);
  logic ccs_q, oci_q, ls_q, pes_q, pss_q, prs_q, pps_q;
  logic pes_d, pss_d, prs_d, pps_d;
  logic disc, conn_edge, oc_edge, rst_fin, en_refused, rst_refused;

  assign disc        = ccs_q & ~connect_i;
  assign conn_edge   = ccs_q ^ connect_i;
  assign oc_edge     = oci_q ^ overcurrent_i;
  assign rst_fin     = prs_q & reset_done_i & ~disc;
  assign en_refused  = cmd_i.set_en & ~ccs_q;
  assign rst_refused = cmd_i.set_rst & ~ccs_q;

  always_comb begin
    pes_d = pes_q;
    if (disc)                      pes_d = 1'b0;
    else if (rst_fin)              pes_d = 1'b1;
    else if (cmd_i.clr_en)         pes_d = 1'b0;
    else if (cmd_i.set_en && ccs_q) pes_d = 1'b1;

    pss_d = pss_q;
    if (disc || rst_fin || cmd_i.clr_en || cmd_i.clr_susp) pss_d = 1'b0;
    else if (cmd_i.set_susp && pes_q)                      pss_d = 1'b1;

    prs_d = prs_q;
    if (disc || rst_fin)               prs_d = 1'b0;
    else if (cmd_i.set_rst && ccs_q)   prs_d = 1'b1;

    pps_d = pps_q;
    if (cmd_i.clr_pwr)      pps_d = 1'b0;
    else if (cmd_i.set_pwr) pps_d = 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ccs_q <= 1'b0;
      oci_q <= 1'b0;
      ls_q  <= 1'b0;
      pes_q <= 1'b0;
      pss_q <= 1'b0;
      prs_q <= 1'b0;
      pps_q <= 1'b0;
    end else begin
      ccs_q <= connect_i;
      oci_q <= overcurrent_i;
      ls_q  <= low_speed_i;
      pes_q <= pes_d;
      pss_q <= pss_d;
      prs_q <= prs_d;
      pps_q <= pps_d;
    end
  end

  always_comb begin
    chg_set_o         = '0;
    chg_set_o[F_CONN] = conn_edge | en_refused | rst_refused;
    chg_set_o[F_EN]   = disc & pes_q;
    chg_set_o[F_SUSP] = cmd_i.clr_susp & pss_q & ~disc;
    chg_set_o[F_OC]   = oc_edge;
    chg_set_o[F_RST]  = rst_fin;
  end

  assign ccs_o  = ccs_q;
  assign pes_o  = pes_q;
  assign pss_o  = pss_q;
  assign poci_o = oci_q;
  assign prs_o  = prs_q;
  assign pps_o  = pps_q;
  assign lsda_o = ls_q & ccs_q;

  assert_en_needs_conn_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(pes_q) |-> $past(ccs_q));
  assert_rst_needs_conn_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(prs_q) |-> $past(ccs_q));
  assert_susp_needs_en_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pss_q |-> pes_q);
  assert_disc_drops_en_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ccs_q && !connect_i) |=> (!pes_q && !prs_q));
  assert_pwr_hold_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!cmd_i.set_pwr && !cmd_i.clr_pwr) |=> $stable(pps_q));
endmodule

// File: rtl/rh_port_chg.sv
`timescale 1ns/1ps
module rh_port_chg
  import rh_port_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [CHG_N-1:0] set_i,
  input  logic [CHG_N-1:0] clr_i,
  output logic [CHG_N-1:0] flag_o
);
  for (genvar i = 0; i < CHG_N; i++) begin : g_flag
    logic flag_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)       flag_q <= 1'b0;
      else if (set_i[i]) flag_q <= 1'b1;   // hardware event wins
      else if (clr_i[i]) flag_q <= 1'b0;
    end
    assign flag_o[i] = flag_q;

    assert_w1c_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (clr_i[i] && !set_i[i]) |=> !flag_q);
    assert_set_wins_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      set_i[i] |=> flag_q);
  end
endmodule

// File: rtl/rh_port_reg.sv
`timescale 1ns/1ps
module rh_port_reg
  import rh_port_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_en_i,
  input  logic [REG_W-1:0] wr_data_i,
  output logic [REG_W-1:0] rd_data_o,
  input  logic             connect_i,
  input  logic             overcurrent_i,
  input  logic             low_speed_i,
  input  logic             reset_done_i,
  output logic             port_reset_o,
  output logic             change_o
);
  port_cmd_t        cmd;
  logic [CHG_N-1:0] chg_clr, chg_set, flags;
  logic ccs, pes, pss, poci, prs, pps, lsda;

  rh_port_cmd u_cmd (
    .wr_en_i   (wr_en_i),
    .wr_data_i (wr_data_i),
    .cmd_o     (cmd),
    .chg_clr_o (chg_clr)
  );

  rh_port_state u_state (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .cmd_i         (cmd),
    .connect_i     (connect_i),
    .overcurrent_i (overcurrent_i),
    .low_speed_i   (low_speed_i),
    .reset_done_i  (reset_done_i),
    .ccs_o         (ccs),
    .pes_o         (pes),
    .pss_o         (pss),
    .poci_o        (poci),
    .prs_o         (prs),
    .pps_o         (pps),
    .lsda_o        (lsda),
    .chg_set_o     (chg_set)
  );

  rh_port_chg u_chg (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .set_i  (chg_set),
    .clr_i  (chg_clr),
    .flag_o (flags)
  );

  always_comb begin
    rd_data_o         = '0;
    rd_data_o[B_CONN] = ccs;
    rd_data_o[B_EN]   = pes;
    rd_data_o[B_SUSP] = pss;
    rd_data_o[B_OC]   = poci;
    rd_data_o[B_RST]  = prs;
    rd_data_o[B_PWR]  = pps;
    rd_data_o[B_LS]   = lsda;
    rd_data_o[CHG_LSB +: CHG_N] = flags;
  end

  assign port_reset_o = prs;
  assign change_o     = |flags;

  assert_zero_write_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && wr_data_i == '0 && !reset_done_i && connect_i == rd_data_o[B_CONN]
     && overcurrent_i == rd_data_o[B_OC]) |=> $stable(rd_data_o[CHG_LSB +: CHG_N]));
  assert_reset_idle_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    port_reset_o |-> rd_data_o[B_CONN]);
endmodule

// File: tb/sim_rh_port_reg.sv
`timescale 1ns/1ps
module sim_rh_port_reg;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        wr_en = 1'b0;
  logic [31:0] wr_data = '0;
  logic [31:0] rd_data;
  logic        conn = 1'b0, oc = 1'b0, ls = 1'b0, done = 1'b0;
  logic        port_reset, change;

  int n_run = 0, n_fail = 0;
  bit finished = 0;

  typedef struct {
    logic [31:0] v;
    string       tag;
  } exp_t;
  exp_t sb[$];

  always #10 clk = ~clk;  // 50 MHz

  rh_port_reg u0 (
    .clk_i         (clk),
    .rst_ni        (rst_ni),
    .wr_en_i       (wr_en),
    .wr_data_i     (wr_data),
    .rd_data_o     (rd_data),
    .connect_i     (conn),
    .overcurrent_i (oc),
    .low_speed_i   (ls),
    .reset_done_i  (done),
    .port_reset_o  (port_reset),
    .change_o      (change)
  );

  // driver: one cycle of stimulus, expected read word pushed to scoreboard
  task automatic step(input logic wr, input logic [31:0] d, input logic c, input logic o,
                      input logic l, input logic dn, input logic [31:0] exp, input string tag);
    @(negedge clk);
    wr_en = wr; wr_data = d; conn = c; oc = o; ls = l; done = dn;
    sb.push_back('{exp, tag});
  endtask

  task automatic check(input logic [31:0] act, input logic [31:0] exp, input string tag);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", tag, act, exp);
    end
  endtask

  // monitor: compare after the edge that consumed the stimulus
  initial begin
    forever begin
      @(posedge clk);
      #5;
      if (sb.size() > 0) begin
        exp_t e;
        e = sb.pop_front();
        check(rd_data, e.v, e.tag);
        check({31'd0, change}, {31'd0, |e.v[20:16]}, {e.tag, " R10 change_o"});
        check({31'd0, port_reset}, {31'd0, e.v[4]}, {e.tag, " R5 port_reset_o"});
      end
    end
  end

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  endtask

  initial begin
    #(20 * 100000);
    n_run++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    #35;
    check(rd_data, 32'h0, "R1 in reset");
    check({31'd0, change}, 32'h0, "R1 change_o in reset");
    @(negedge clk);
    rst_ni = 1'b1;
    //    wr    data          c  o  l  dn  expected
    step(0, 32'h0,       0, 0, 0, 0, 32'h0,      "R1 after reset");
    step(1, 32'h2,       0, 0, 0, 0, 32'h10000,  "R3 enable refused");
    step(1, 32'h10000,   0, 0, 0, 0, 32'h0,      "R7 clear conn-change");
    step(1, 32'h100,     0, 0, 0, 0, 32'h100,    "R6 power on");
    step(0, 32'h0,       1, 0, 1, 0, 32'h10301,  "R2 connect low speed");
    step(1, 32'h10000,   1, 0, 1, 0, 32'h301,    "R7 ack connect");
    step(1, 32'h10,      1, 0, 1, 0, 32'h311,    "R5 start reset");
    step(1, 32'h0,       1, 0, 1, 0, 32'h311,    "R9 zero write");
    step(0, 32'h0,       1, 0, 1, 1, 32'h100303, "R5 reset done");
    step(1, 32'h100000,  1, 0, 1, 0, 32'h303,    "R7 ack reset change");
    step(1, 32'h4,       1, 0, 1, 0, 32'h307,    "R4 suspend");
    step(1, 32'h8,       1, 0, 1, 0, 32'h40303,  "R4 resume");
    step(1, 32'h40000,   1, 0, 1, 0, 32'h303,    "R7 ack suspend change");
    step(1, 32'h1,       1, 0, 1, 0, 32'h301,    "R3 disable");
    step(1, 32'h2,       1, 0, 1, 0, 32'h303,    "R3 enable");
    step(0, 32'h0,       1, 1, 1, 0, 32'h8030B,  "R8 over-current rise");
    step(1, 32'h80000,   1, 1, 1, 0, 32'h30B,    "R7 ack over-current");
    step(0, 32'h0,       1, 0, 1, 0, 32'h80303,  "R8 over-current fall");
    step(1, 32'h80000,   1, 0, 1, 0, 32'h303,    "R7 ack over-current");
    step(1, 32'h3,       1, 0, 1, 0, 32'h301,    "R3 clear wins");
    step(1, 32'h2,       1, 0, 1, 0, 32'h303,    "R3 re-enable");
    step(1, 32'h4,       1, 0, 1, 0, 32'h307,    "R4 suspend again");
    step(0, 32'h0,       0, 0, 1, 0, 32'h30100,  "R8 disconnect");
    step(1, 32'h10000,   1, 0, 1, 0, 32'h30301,  "R7 set beats clear");
    step(1, 32'h30000,   1, 0, 1, 0, 32'h301,    "R7 ack both");
    step(1, 32'h200,     1, 0, 1, 0, 32'h201,    "R6 power off");
    step(0, 32'h0,       1, 0, 1, 1, 32'h201,    "R5 stray done ignored");
    step(1, 32'h4,       1, 0, 1, 0, 32'h201,    "R4 suspend while disabled");
    step(1, 32'h300,     1, 0, 1, 0, 32'h201,    "R6 power clear wins");
    step(1, 32'h100,     1, 0, 1, 0, 32'h301,    "R6 power on");
    step(0, 32'h0,       0, 0, 1, 0, 32'h10100,  "R8 disconnect while disabled");
    step(1, 32'h10000,   0, 0, 1, 0, 32'h100,    "R7 ack");
    step(1, 32'h10,      0, 0, 1, 0, 32'h10100,  "R5 reset refused");
    @(negedge clk);
    wr_en = 1'b0; done = 1'b0;
    while (sb.size() > 0) @(negedge clk);
    finish_run();
  end
endmodule